// File: doc/BRIEF.md
# Addressed I2C Transfer Sequencer

This block turns one transfer request into the ordered list of bus commands that a lower bit-level engine carries out. The engine understands five commands: bus reset, START, STOP, write one byte (and report whether it was acknowledged), and read one byte (ending with ACK or NACK). The sequencer accepts a request holding an operation (probe, write or read), a 7-bit device number, a register address of zero to `ADDR_BYTES` bytes and a byte count. It issues the commands one at a time and finishes with a single-cycle status report.

Write payload is pulled from a valid/ready byte stream while the transfer runs. Read payload is pushed out on a second valid/ready byte stream. A read with a register address does not use a repeated START. It sends the address in a write phase, closes it with a full STOP, and then opens a new START for the read phase. An optional per-request overflow mode takes the address bits that lie above the used address bytes, masks them with the `OVF_MASK` parameter, and merges them into the device number. This is how small memories that decode extra address bits from the device number are reached. The very first request after reset is preceded by one bus-reset command, which clears any device left mid-byte.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the block is idle with `req_ready`=1 and no command, status or read output. The first accepted request is preceded by exactly one bus-reset command (code 5). Later requests start directly with START.
- R2: A probe (op 0) issues START (code 1), then a write (code 3) of {device,0}, then STOP (code 2). It reports status 0 when that byte was acknowledged and status 1 when it was not.
- R3: For a write (op 1), and for a read (op 2) with a nonzero address length, a NACK on {device,0} is followed by STOP. The transfer then ends with status 1 and a failure count of 0.
- R4: The register address bytes follow the {device,0} byte, most significant used byte first, and their number equals `req_alen`.
- R5: During a write, each payload byte is taken from the write stream and sent. A NACK on a payload byte does not end the transfer. After the last byte comes STOP, and status is 3 with `st_fails` equal to the number of NACKed payload bytes, or 0 with `st_fails`=0 if none were NACKed.
- R6: A read with address length 0 goes from START straight to writing {device,1}. The acknowledge of that byte is not examined.
- R7: A read with a nonzero address length issues START, {device,0}, the address bytes, STOP, START and then {device,1}.
- R8: A read issues `req_len` read commands (code 4). `cmd_nack_last` is 1 only on the last one. Each received byte is delivered in order on the read stream and held until taken. STOP follows the last byte and status is 0.
- R9: When `req_ovf`=1 and `req_alen` is less than `ADDR_BYTES`, the device number actually sent becomes `req_chip | ((req_addr >> 8*req_alen) & OVF_MASK)`, in every device byte of the transfer. When `req_ovf`=0 the device number is sent unchanged.
- R10: A NACK on any register address byte is followed at once by STOP. The transfer ends with status 2 and sends no further bytes.
- R11: A write or read with `req_len`=0 completes its addressing and then issues STOP, with no payload byte and no read command.
- R12: A command stays presented, unchanged, from the cycle `cmd_valid` rises until the cycle the engine pulses `eng_done`. Only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 probe, 1 write, 2 read (3 acts as probe) |
| req_chip | input | 7 | Device number |
| req_addr | input | 8*ADDR_BYTES | Register address |
| req_alen | input | clog2(ADDR_BYTES+1) | Register address bytes, 0 to ADDR_BYTES |
| req_len | input | LEN_W | Payload byte count |
| req_ovf | input | 1 | Merge high address bits into device number |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Sequencer takes a write payload byte |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read payload byte |
| cmd_valid | output | 1 | Command presented to the bit engine |
| cmd_code | output | 3 | 1 START, 2 STOP, 3 write byte, 4 read byte, 5 bus reset |
| cmd_wdata | output | 8 | Byte to write for code 3 |
| cmd_nack_last | output | 1 | For code 4: answer the byte with NACK |
| eng_done | input | 1 | One-cycle pulse: presented command finished |
| eng_nack | input | 1 | With eng_done after code 3: byte was not acknowledged |
| eng_rdata | input | 8 | With eng_done after code 4: received byte |
| st_valid | output | 1 | One-cycle transfer completion pulse |
| st_code | output | 2 | 0 ok, 1 no device, 2 address refused, 3 payload NACKs |
| st_fails | output | LEN_W | Number of NACKed write payload bytes |

## Verification
The bench goes after the points where a sequencer most easily slips. One is the switch between the zero-length address path of a read and the stop-and-restart path; a design that mixes them up would send a STOP/START pair with no address, or skip the address write. Another is the address byte order across every length up to the maximum, where a design with a swapped or off-by-one index sends bytes in the wrong order or one byte too many or too few. It also injects refused address and payload bytes: a wrong abort rule either ends a write early on the first payload NACK or keeps sending after a refused address. Overflow merging is checked with bits above the mask and at full address length, where a design shifting by the wrong amount would address the wrong device. The last-byte NACK flag and zero-length transfers are checked under a stalling read consumer, which catches a dropped byte or an extra read command.

// File: rtl/i2c_seq_pkg.sv
// Shared encodings for the addressed transfer sequencer.
// Assumes: the bit engine decodes the command codes below exactly.
package i2c_seq_pkg;

    // Commands presented to the bit engine.
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_START = 3'd1,
        CMD_STOP  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_READ  = 3'd4,
        CMD_RESET = 3'd5
    } cmd_e;

    // Requested operation.
    localparam logic [1:0] OP_PROBE = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    // Completion codes.
    localparam logic [1:0] ST_OK        = 2'd0;
    localparam logic [1:0] ST_NODEV     = 2'd1;
    localparam logic [1:0] ST_ADDR_ERR  = 2'd2;
    localparam logic [1:0] ST_DATA_FAIL = 2'd3;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE,
        S_BRST,
        S_START1,
        S_CHIPW,
        S_ADDR,
        S_STOPM,
        S_START2,
        S_CHIPR,
        S_WWAIT,
        S_WSEND,
        S_RBYTE,
        S_RPUSH,
        S_STOPE,
        S_REPORT
    } state_e;

endpackage

// File: rtl/i2c_seq_cnt.sv
// Loadable down counter used for the address byte index and the payload
// bytes remaining.
// Assumes: dec is never raised while the count is zero.
module i2c_seq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] q
);

    // Hold, load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (dec)
            q <= q - 1'b1;
    end

    // R12: the sequencer only steps a counter that still has work left.
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (q != '0));

endmodule

// File: rtl/i2c_seq_addrgen.sv
// Device-number merge and register-address byte selection.
// Folds masked high address bits into the device number when overflow is
// requested, and picks one address byte by index (0 = least significant).
// Assumes: alen never exceeds ADDR_BYTES; idx is below alen when used.
module i2c_seq_addrgen #(
    parameter int          ADDR_BYTES = 4,
    parameter logic [6:0]  OVF_MASK   = 7'h07,
    localparam int         ADDR_W     = 8 * ADDR_BYTES,
    localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]        chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic              ovf_en,
    input  logic [ALEN_W-1:0] idx,
    output logic [6:0]        eff_chip,
    output logic [7:0]        addr_byte
);

    logic [7:0]        byte_arr [ADDR_BYTES];
    logic [ADDR_W-1:0] shifted;
    logic [6:0]        high_bits;

    // Split the address into bytes.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_bytes
        assign byte_arr[g] = addr[8*g +: 8];
    end

    // Bits just above the used address bytes, merged when enabled.
    always_comb begin
        shifted   = '0;
        high_bits = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (alen == ALEN_W'(k)) begin
                shifted   = addr >> (8 * k);
                high_bits = shifted[6:0];
            end
        end
        eff_chip = ovf_en ? (chip | (high_bits & OVF_MASK)) : chip;
    end

    // Select the address byte named by the index.
    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == ALEN_W'(k))
                addr_byte = byte_arr[k];
        end
    end

endmodule

// File: rtl/i2c_seq_fsm.sv
// Transfer control: latches the request, walks through the bus command
// list, moves payload bytes between the engine and the two streams, and
// forms the completion code.
// Assumes: eng_done pulses for one cycle only while cmd_valid is high.
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 8,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_ovf,
    output logic [6:0]        q_chip,
    output logic [ADDR_W-1:0] q_addr,
    output logic [ALEN_W-1:0] q_alen,
    output logic              q_ovf,
    input  logic [6:0]        eff_chip,
    input  logic [7:0]        addr_byte,
    output logic              idx_load,
    output logic [ALEN_W-1:0] idx_load_val,
    output logic              idx_dec,
    input  logic [ALEN_W-1:0] idx_q,
    output logic              rem_load,
    output logic [LEN_W-1:0]  rem_load_val,
    output logic              rem_dec,
    input  logic [LEN_W-1:0]  rem_q,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack_last,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              st_valid,
    output logic [1:0]        st_code,
    output logic [LEN_W-1:0]  st_fails
);

    state_e           state;
    logic             reset_done;
    logic [1:0]       q_op;
    logic [7:0]       wbuf;
    logic [7:0]       rbuf;
    logic [LEN_W-1:0] fails;
    logic [1:0]       code;
    logic             idx_zero;
    logic             rem_zero;
    logic             rem_one;
    logic             is_read;
    logic             is_write;
    logic             acked;
    state_e           after_addr;

    assign idx_zero = (idx_q == '0);
    assign rem_zero = (rem_q == '0);
    assign rem_one  = (rem_q == LEN_W'(1));
    assign is_read  = (q_op == OP_READ);
    assign is_write = (q_op == OP_WRITE);
    assign acked    = eng_done && !eng_nack;

    // Where to go once the address phase is complete.
    always_comb begin
        if (is_read)
            after_addr = S_STOPM;
        else if (rem_zero)
            after_addr = S_STOPE;
        else
            after_addr = S_WWAIT;
    end

    // Command presented in each state.
    always_comb begin
        cmd_valid     = 1'b1;
        cmd_code      = CMD_NONE;
        cmd_wdata     = 8'h00;
        cmd_nack_last = 1'b0;
        case (state)
            S_BRST:   cmd_code = CMD_RESET;
            S_START1,
            S_START2: cmd_code = CMD_START;
            S_STOPM,
            S_STOPE:  cmd_code = CMD_STOP;
            S_CHIPW: begin
                cmd_code  = CMD_WRITE;
                cmd_wdata = {eff_chip, 1'b0};
            end
            S_CHIPR: begin
                cmd_code  = CMD_WRITE;
                cmd_wdata = {eff_chip, 1'b1};
            end
            S_ADDR: begin
                cmd_code  = CMD_WRITE;
                cmd_wdata = addr_byte;
            end
            S_WSEND: begin
                cmd_code  = CMD_WRITE;
                cmd_wdata = wbuf;
            end
            S_RBYTE: begin
                cmd_code      = CMD_READ;
                cmd_nack_last = rem_one;
            end
            default:  cmd_valid = 1'b0;
        endcase
    end

    // Stream, request and status strobes.
    always_comb begin
        req_ready    = (state == S_IDLE);
        wr_ready     = (state == S_WWAIT);
        rd_valid     = (state == S_RPUSH);
        rd_data      = rbuf;
        st_valid     = (state == S_REPORT);
        st_code      = code;
        st_fails     = fails;
        idx_load     = (state == S_CHIPW) && acked;
        idx_load_val = q_alen - 1'b1;
        idx_dec      = (state == S_ADDR) && acked && !idx_zero;
        rem_load     = req_valid && (state == S_IDLE);
        rem_load_val = req_len;
        rem_dec      = ((state == S_WSEND) && eng_done) ||
                       ((state == S_RPUSH) && rd_ready);
    end

    // Advance the sequencer and keep its transfer record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            reset_done <= 1'b0;
            q_op       <= OP_PROBE;
            q_chip     <= '0;
            q_addr     <= '0;
            q_alen     <= '0;
            q_ovf      <= 1'b0;
            wbuf       <= '0;
            rbuf       <= '0;
            fails      <= '0;
            code       <= ST_OK;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    q_op   <= req_op;
                    q_chip <= req_chip;
                    q_addr <= req_addr;
                    q_alen <= req_alen;
                    q_ovf  <= req_ovf;
                    fails  <= '0;
                    code   <= ST_OK;
                    state  <= reset_done ? S_START1 : S_BRST;
                end
                S_BRST: if (eng_done) begin
                    reset_done <= 1'b1;
                    state      <= S_START1;
                end
                S_START1: if (eng_done)
                    state <= (is_read && q_alen == '0) ? S_CHIPR : S_CHIPW;
                S_CHIPW: if (eng_done) begin
                    if (eng_nack) begin
                        code  <= ST_NODEV;
                        state <= S_STOPE;
                    end else if (!is_read && !is_write)
                        state <= S_STOPE;
                    else if (q_alen != '0)
                        state <= S_ADDR;
                    else
                        state <= after_addr;
                end
                S_ADDR: if (eng_done) begin
                    if (eng_nack) begin
                        code  <= ST_ADDR_ERR;
                        state <= S_STOPE;
                    end else if (idx_zero)
                        state <= after_addr;
                end
                S_STOPM:  if (eng_done) state <= S_START2;
                S_START2: if (eng_done) state <= S_CHIPR;
                S_CHIPR:  if (eng_done) state <= rem_zero ? S_STOPE : S_RBYTE;
                S_WWAIT: if (wr_valid) begin
                    wbuf  <= wr_data;
                    state <= S_WSEND;
                end
                S_WSEND: if (eng_done) begin
                    if (eng_nack)
                        fails <= fails + 1'b1;
                    state <= rem_one ? S_STOPE : S_WWAIT;
                end
                S_RBYTE: if (eng_done) begin
                    rbuf  <= eng_rdata;
                    state <= S_RPUSH;
                end
                S_RPUSH: if (rd_ready)
                    state <= rem_one ? S_STOPE : S_RBYTE;
                S_STOPE: if (eng_done) begin
                    if (code == ST_OK && fails != '0)
                        code <= ST_DATA_FAIL;
                    state <= S_REPORT;
                end
                S_REPORT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // R12: a command does not change or vanish before the engine finishes it.
    a_r12_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_wdata)));

    // R1: nothing but the bus reset goes out before the first reset completes.
    a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !reset_done) |-> (cmd_code == CMD_RESET));

    // R8: a read byte waits on the stream, unchanged, until taken.
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R3: a missing device never reports payload failures.
    a_r3_nodev_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_code == ST_NODEV) |-> (st_fails == '0));

    // R5: a nonzero failure count always carries the payload-failure code.
    a_r5_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_fails != '0) |-> (st_code == ST_DATA_FAIL));

    // R12: the completion report lasts one cycle and no command overlaps it.
    a_r12_report_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> (!st_valid && !cmd_valid));

endmodule

// File: rtl/i2c_xfer_seq.sv
// Top of the addressed transfer sequencer: request control, device-number
// merge with address byte selection, and the two counters.
// Assumes: req_alen <= ADDR_BYTES; bit timing lives in the engine.
module i2c_xfer_seq #(
    parameter int          ADDR_BYTES = 4,
    parameter int          LEN_W      = 8,
    parameter logic [6:0]  OVF_MASK   = 7'h07,
    localparam int         ADDR_W     = 8 * ADDR_BYTES,
    localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_ovf,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack_last,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              st_valid,
    output logic [1:0]        st_code,
    output logic [LEN_W-1:0]  st_fails
);

    logic [6:0]        q_chip;
    logic [ADDR_W-1:0] q_addr;
    logic [ALEN_W-1:0] q_alen;
    logic              q_ovf;
    logic [6:0]        eff_chip;
    logic [7:0]        addr_byte;
    logic              idx_load;
    logic [ALEN_W-1:0] idx_load_val;
    logic              idx_dec;
    logic [ALEN_W-1:0] idx_q;
    logic              rem_load;
    logic [LEN_W-1:0]  rem_load_val;
    logic              rem_dec;
    logic [LEN_W-1:0]  rem_q;

    i2c_seq_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .LEN_W      (LEN_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_chip      (req_chip),
        .req_addr      (req_addr),
        .req_alen      (req_alen),
        .req_len       (req_len),
        .req_ovf       (req_ovf),
        .q_chip        (q_chip),
        .q_addr        (q_addr),
        .q_alen        (q_alen),
        .q_ovf         (q_ovf),
        .eff_chip      (eff_chip),
        .addr_byte     (addr_byte),
        .idx_load      (idx_load),
        .idx_load_val  (idx_load_val),
        .idx_dec       (idx_dec),
        .idx_q         (idx_q),
        .rem_load      (rem_load),
        .rem_load_val  (rem_load_val),
        .rem_dec       (rem_dec),
        .rem_q         (rem_q),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_data       (wr_data),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .rd_data       (rd_data),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .cmd_wdata     (cmd_wdata),
        .cmd_nack_last (cmd_nack_last),
        .eng_done      (eng_done),
        .eng_nack      (eng_nack),
        .eng_rdata     (eng_rdata),
        .st_valid      (st_valid),
        .st_code       (st_code),
        .st_fails      (st_fails)
    );

    i2c_seq_addrgen #(
        .ADDR_BYTES (ADDR_BYTES),
        .OVF_MASK   (OVF_MASK)
    ) u_addrgen (
        .chip      (q_chip),
        .addr      (q_addr),
        .alen      (q_alen),
        .ovf_en    (q_ovf),
        .idx       (idx_q),
        .eff_chip  (eff_chip),
        .addr_byte (addr_byte)
    );

    i2c_seq_cnt #(.W(ALEN_W)) u_idx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idx_load),
        .load_val (idx_load_val),
        .dec      (idx_dec),
        .q        (idx_q)
    );

    i2c_seq_cnt #(.W(LEN_W)) u_rem_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rem_load),
        .load_val (rem_load_val),
        .dec      (rem_dec),
        .q        (rem_q)
    );

endmodule

// File: tb/i2c_xfer_seq_bench.sv
// Bench: behavioural bit engine plus stream source and sink; every transfer's
// command list, status and read bytes are compared with values built here.
module i2c_xfer_seq_bench;

    localparam int         CLK_PERIOD = 10;
    localparam logic [6:0] MASK       = 7'h07;
    localparam int         NB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [6:0]  req_chip = '0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_alen = '0;
    logic [7:0]  req_len = '0;
    logic        req_ovf = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [7:0]  cmd_wdata;
    logic        cmd_nack_last;
    logic        eng_done = 1'b0;
    logic        eng_nack = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        st_valid;
    logic [1:0]  st_code;
    logic [7:0]  st_fails;

    i2c_xfer_seq u_i2c_xfer_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen),
        .req_len(req_len), .req_ovf(req_ovf),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
        .cmd_nack_last(cmd_nack_last),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .st_valid(st_valid), .st_code(st_code), .st_fails(st_fails)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Command log written by the engine model.
    logic [2:0] lg_code [64];
    logic [7:0] lg_data [64];
    logic       lg_last [64];
    int         lg_n = 0;
    int         rcount = 0;

    // Engine model: accepts a command, answers two cycles later.
    initial begin : engine
        logic [2:0] c;
        logic [7:0] d;
        logic       nk;
        logic [7:0] rv;
        bit         first;
        first = 0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                c  = cmd_code;
                d  = cmd_wdata;
                nk = 1'b0;
                rv = 8'h00;
                if (lg_n < 64) begin
                    lg_code[lg_n] = c;
                    lg_data[lg_n] = d;
                    lg_last[lg_n] = cmd_nack_last;
                end
                lg_n++;
                case (c)
                    3'd1: first = 1;
                    3'd3: begin
                        nk    = first ? (d[7:4] != 4'hA) : (d == 8'hEE);
                        first = 0;
                    end
                    3'd4: begin
                        rv = 8'h30 + 8'(rcount);
                        rcount++;
                    end
                    default: ;
                endcase
                @(negedge clk);
                @(negedge clk);
                check("R12", "command held until done", {29'd0, cmd_valid, 2'd0} | 32'(cmd_code == c), 32'h4 | 32'h1);
                eng_nack  = nk;
                eng_rdata = rv;
                eng_done  = 1'b1;
                @(negedge clk);
                eng_done  = 1'b0;
            end
        end
    end

    // Write payload source.
    logic [7:0] wq [8];
    int wi = 0;
    int wn = 0;
    always @(negedge clk) begin
        if (wi < wn) begin
            wr_valid = 1'b1;
            wr_data  = wq[wi];
            if (wr_ready) wi++;
        end else begin
            wr_valid = 1'b0;
        end
    end

    // Read payload sink with a stalling ready pattern.
    logic [7:0] rq [8];
    int ri = 0;
    int cyc = 0;
    always @(negedge clk) begin
        logic nr;
        cyc++;
        nr = (cyc % 3) != 0;
        if (rd_valid && nr) begin
            if (ri < 8) rq[ri] = rd_data;
            ri++;
        end
        rd_ready = nr;
    end

    // Status monitor.
    bit         st_seen = 0;
    logic [1:0] st_c;
    logic [7:0] st_f;
    always @(negedge clk) begin
        if (st_valid) begin
            st_seen = 1;
            st_c    = st_code;
            st_f    = st_fails;
        end
    end

    // Expected command list.
    logic [2:0] ex_code [64];
    logic [7:0] ex_data [64];
    logic       ex_last [64];
    int         ex_n;
    bit         first_xfer = 1;

    task automatic push(input logic [2:0] c, input logic [7:0] d, input logic l);
        ex_code[ex_n] = c;
        ex_data[ex_n] = d;
        ex_last[ex_n] = l;
        ex_n++;
    endtask

    task automatic run(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] addr,
                       input int alen, input int len, input logic ovf, input string tag);
        logic [6:0]  eff;
        logic [31:0] hi;
        logic [7:0]  b;
        bit          present;
        bit          stop_now;
        int          ecode;
        int          efail;
        // Expected behaviour from the requirements.
        eff = chip;
        if (ovf && alen < NB) begin
            hi  = addr >> (8 * alen);
            eff = chip | (hi[6:0] & MASK);
        end
        present  = (eff[6:3] == 4'b1010);
        ex_n     = 0;
        ecode    = 0;
        efail    = 0;
        stop_now = 0;
        if (first_xfer) push(3'd5, 8'h00, 1'b0);
        push(3'd1, 8'h00, 1'b0);
        if (op == 2'd0) begin
            push(3'd3, {eff, 1'b0}, 1'b0);
            push(3'd2, 8'h00, 1'b0);
            ecode    = present ? 0 : 1;
            stop_now = 1;
        end else if (op == 2'd1 || alen > 0) begin
            push(3'd3, {eff, 1'b0}, 1'b0);
            if (!present) begin
                push(3'd2, 8'h00, 1'b0);
                ecode    = 1;
                stop_now = 1;
            end
            for (int i = alen - 1; i >= 0; i--) begin
                if (!stop_now) begin
                    hi = addr >> (8 * i);
                    b  = hi[7:0];
                    push(3'd3, b, 1'b0);
                    if (b == 8'hEE) begin
                        push(3'd2, 8'h00, 1'b0);
                        ecode    = 2;
                        stop_now = 1;
                    end
                end
            end
            if (!stop_now) begin
                if (op == 2'd1) begin
                    for (int k = 0; k < len; k++) begin
                        push(3'd3, wq[k], 1'b0);
                        if (wq[k] == 8'hEE) efail++;
                    end
                    push(3'd2, 8'h00, 1'b0);
                    ecode    = (efail != 0) ? 3 : 0;
                    stop_now = 1;
                end else begin
                    push(3'd2, 8'h00, 1'b0);
                    push(3'd1, 8'h00, 1'b0);
                end
            end
        end
        if (op == 2'd2 && !stop_now) begin
            push(3'd3, {eff, 1'b1}, 1'b0);
            for (int k = 0; k < len; k++) push(3'd4, 8'h00, k == len - 1);
            push(3'd2, 8'h00, 1'b0);
        end
        // Drive the request.
        @(negedge clk);
        lg_n     = 0;
        rcount   = 0;
        ri       = 0;
        wi       = 0;
        wn       = (op == 2'd1) ? len : 0;
        st_seen  = 0;
        req_op   = op;
        req_chip = chip;
        req_addr = addr;
        req_alen = 3'(alen);
        req_len  = 8'(len);
        req_ovf  = ovf;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!st_seen) @(negedge clk);
        @(negedge clk);
        wn = 0;
        first_xfer = 0;
        // Compare.
        check(tag, "command count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            check(tag, $sformatf("cmd %0d code", i), lg_code[i], ex_code[i]);
            if (ex_code[i] == 3'd3)
                check(tag, $sformatf("cmd %0d byte", i), lg_data[i], ex_data[i]);
            if (ex_code[i] == 3'd4)
                check("R8", $sformatf("cmd %0d nack flag", i), lg_last[i], ex_last[i]);
        end
        check(tag, "status code", st_c, ecode);
        check(tag, "fail count", st_f, efail);
        if (op == 2'd2 && ecode == 0) begin
            check("R8", "read byte count", ri, len);
            for (int k = 0; k < len && k < ri; k++)
                check("R8", $sformatf("read byte %0d", k), rq[k], 8'h30 + k);
        end else begin
            check(tag, "no read bytes", ri, 0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset.
        check("R1", "req_ready after reset", req_ready, 1);
        check("R1", "cmd_valid after reset", cmd_valid, 0);
        check("R1", "st_valid after reset", st_valid, 0);
        check("R1", "rd_valid after reset", rd_valid, 0);

        // R1: first request carries the bus reset.
        run(2'd0, 7'h50, 32'h0, 0, 0, 1'b0, "R1");

        // R2: probe sweep across present and absent devices.
        for (int c = 7'h40; c < 7'h60; c++)
            run(2'd0, 7'(c), 32'h0, 0, 0, 1'b0, "R2");

        // R3: absent device on write and on addressed read.
        run(2'd1, 7'h23, 32'h44, 1, 2, 1'b0, "R3");
        run(2'd2, 7'h61, 32'h44, 2, 2, 1'b0, "R3");

        // R4 / R11: writes across all address and payload lengths.
        for (int a = 0; a <= NB; a++)
            for (int l = 0; l <= 3; l++) begin
                for (int k = 0; k < 8; k++) wq[k] = 8'(8'h10 + k + a);
                run(2'd1, 7'h52, 32'h1A2B3C4D, a, l, 1'b0, (l == 0) ? "R11" : "R4");
            end

        // R5: payload NACKs counted, transfer continues.
        for (int k = 0; k < 8; k++) wq[k] = 8'h20 + 8'(k);
        wq[1] = 8'hEE;
        run(2'd1, 7'h51, 32'h0000_0077, 1, 3, 1'b0, "R5");
        wq[0] = 8'hEE; wq[2] = 8'hEE; wq[3] = 8'hEE;
        run(2'd1, 7'h51, 32'h0000_0077, 2, 4, 1'b0, "R5");

        // R6 / R7 / R8 / R11: reads across address and payload lengths.
        for (int a = 0; a <= NB; a++)
            for (int l = 0; l <= 4; l++)
                run(2'd2, 7'h55, 32'h01020304, a, l, 1'b0,
                    (l == 0) ? "R11" : ((a == 0) ? "R6" : "R7"));

        // R9: overflow merge.
        for (int k = 0; k < 8; k++) wq[k] = 8'h5A;
        run(2'd1, 7'h50, 32'h0000_0512, 1, 1, 1'b1, "R9");
        run(2'd2, 7'h50, 32'h0006_1234, 2, 2, 1'b1, "R9");
        run(2'd2, 7'h50, 32'h0006_1234, 2, 2, 1'b0, "R9");
        run(2'd1, 7'h50, 32'h0000_FF12, 1, 1, 1'b1, "R9");
        run(2'd1, 7'h50, 32'h0000_0003, 0, 1, 1'b1, "R9");
        run(2'd2, 7'h50, 32'h0712_3456, 4, 1, 1'b1, "R9");
        run(2'd0, 7'h48, 32'h0000_0A00, 1, 0, 1'b1, "R9");

        // R10: refused address bytes at different positions.
        run(2'd1, 7'h53, 32'h00EE_0000, 3, 2, 1'b0, "R10");
        run(2'd1, 7'h53, 32'h0000_11EE, 2, 2, 1'b0, "R10");
        run(2'd2, 7'h53, 32'hEE00_0000, 4, 3, 1'b0, "R10");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule